// File: doc/BRIEF.md
# Interrupt and DMA Request Steering

This block sits on an ISA adapter card between the card's own logic and the bus. It carries two interrupt requests from the card onto bus interrupt lines that can be chosen, and one card DMA request onto one of two bus DMA channels. The bus acknowledge for the chosen channel goes back to the card. A small write-only register port holds the routing choices and the operating mode. Every path from a request or acknowledge input to an output is combinational. The registers only choose which of these paths are active.

A two-bit mode field gives the shared pins their role. In DMA mode the two bus-side DMA pins carry the card's request, the card-side request pin is an input, and the card-side acknowledge pin returns the bus acknowledge. In extended-interrupt mode the two bus-side DMA pins become interrupt lines 6 and 7, so eight lines can be routed. The card-side request and acknowledge pins then carry chip selects 2 and 3 from the card's address decoder, and the two bus acknowledge inputs are passed out as address bits 12 and 13. Every bus-side output has its own output enable. A line that no enabled source selects keeps its enable low and is never driven.

Top module: `req_steer`

## Requirements
- R1: After reset the mode field is 00 and every routing is disabled. All output enables are low, the card acknowledge pin is high and addr_hi_o is 0.
- R2: An interrupt routing that is enabled and points at a destination below 6 drives that bus line with the level of its card input, with its enable high, and with no clock delay.
- R3: When both enabled routings point at the same destination, the line carries the OR of the two inputs.
- R4: A bus line that no active routing selects has its enable low and its data output at 0. This applies to the interrupt lines and to the shared DMA pins.
- R5: Destinations 6 and 7 appear on shared pins 0 and 1 only in mode 01. In any other mode a routing aimed at them drives nothing.
- R6: In mode 00 with DMA enabled, the card request drives only the shared pin chosen by the channel bit, and that pin's enable is high. The other shared pin is undriven.
- R7: In mode 00 the card acknowledge pin (active low) equals the bus acknowledge input of the chosen channel. It stays high while DMA is disabled.
- R8: In mode 01 the card request pin is driven with chip select 2 (cs_n_i bit 0) and the card acknowledge pin with chip select 3 (cs_n_i bit 1). addr_hi_o equals isa_ack_pin_i. In any other mode the card request pin's enable is low and addr_hi_o is 0.
- R9: In mode 10 or 11 the shared pins and the card request pin are undriven and the card acknowledge pin is high. Interrupt routing to destinations 0 to 5 still works.
- R10: A write takes effect at the clock edge where cfg_we_i is high. The addresses are: 0 for the mode (data bits 1:0); 1 and 2 for the routings of interrupt inputs 0 and 1 (bit 3 enables, bits 2:0 give the destination); 3 for DMA (bit 1 enables, bit 0 gives the channel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 4 | Register write data |
| irq_in_i | input | 2 | Interrupt requests from card logic, active high |
| card_req_pin_i | input | 1 | Card DMA request (used in mode 00) |
| card_req_pin_o | output | 1 | Chip select 2 (driven in mode 01) |
| card_req_pin_oe_o | output | 1 | Enable for card_req_pin_o |
| card_ack_pin_o | output | 1 | Card DMA acknowledge, active low, or chip select 3 |
| cs_n_i | input | 2 | Chip selects 2 and 3 from the card decoder |
| isa_irq_o | output | 6 | Bus interrupt lines 0 to 5 |
| isa_irq_oe_o | output | 6 | Per-line enables for isa_irq_o |
| isa_dma_pin_o | output | 2 | Bus DMA requests, or interrupt lines 6 and 7 |
| isa_dma_pin_oe_o | output | 2 | Per-pin enables for isa_dma_pin_o |
| isa_ack_pin_i | input | 2 | Bus DMA acknowledges (active low), or address bits 13:12 |
| addr_hi_o | output | 2 | Address bits 13:12 passed out in mode 01 |

## Verification
The assertions assume that register writes are synchronous to clk_i, and that the request, acknowledge and chip-select inputs only settle the combinational outputs and never feed back into the registers. The stimulus follows this. It changes configuration only through timed writes on the falling edge. It changes the pin inputs only between clock edges, and it lets them settle before each sample is taken. The checker watches the single-channel rule, the zero value on undriven pins and the roles tied to each mode. It does this in every mode the bench visits, including the two reserved codes.

// File: rtl/req_steer_pkg.sv
package req_steer_pkg;
  typedef logic [1:0] mode_t;
  localparam mode_t MODE_DMA = 2'b00;
  localparam mode_t MODE_EXT = 2'b01;
endpackage

// File: rtl/req_steer_cfg.sv
module req_steer_cfg
  import req_steer_pkg::*;
#(
  parameter int N_SRC = 2,
  parameter int DST_W = 3,
  parameter int CH_W  = 1,
  parameter int A_W   = 2,
  parameter int REG_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [A_W-1:0]              addr_i,
  input  logic [REG_W-1:0]            wdata_i,
  output mode_t                       mode_o,
  output logic [N_SRC-1:0]            route_en_o,
  output logic [N_SRC-1:0][DST_W-1:0] route_dst_o,
  output logic                        dma_en_o,
  output logic [CH_W-1:0]             dma_ch_o
);
  localparam int DMA_ADDR = N_SRC + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= MODE_DMA;
      route_en_o  <= '0;
      route_dst_o <= '0;
      dma_en_o    <= 1'b0;
      dma_ch_o    <= '0;
    end else if (we_i) begin
      if (addr_i == '0) mode_o <= wdata_i[1:0];
      for (int s = 0; s < N_SRC; s++) begin
        if (addr_i == A_W'(s + 1)) begin
          route_en_o[s]  <= wdata_i[DST_W];
          route_dst_o[s] <= wdata_i[DST_W-1:0];
        end
      end
      if (addr_i == A_W'(DMA_ADDR)) begin
        dma_en_o <= wdata_i[CH_W];
        dma_ch_o <= wdata_i[CH_W-1:0];
      end
    end
  end
endmodule

// File: rtl/req_steer_xbar.sv
module req_steer_xbar #(
  parameter int N_SRC = 2,
  parameter int N_DST = 8,
  parameter int DST_W = 3
) (
  input  logic [N_SRC-1:0]            irq_i,
  input  logic [N_SRC-1:0]            en_i,
  input  logic [N_SRC-1:0][DST_W-1:0] dst_i,
  input  logic [N_DST-1:0]            dst_mask_i,
  output logic [N_DST-1:0]            lvl_o,
  output logic [N_DST-1:0]            oe_o
);
  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    logic [N_SRC-1:0] hit;
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign hit[s] = en_i[s] && (dst_i[s] == DST_W'(d));
    end
    // sources sharing a line are wire-ORed
    assign oe_o[d]  = dst_mask_i[d] & (|hit);
    assign lvl_o[d] = dst_mask_i[d] & (|(hit & irq_i));
  end
endmodule

// File: rtl/req_steer_dma.sv
module req_steer_dma #(
  parameter int N_DMA = 2,
  parameter int CH_W  = 1
) (
  input  logic             active_i,
  input  logic             en_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             req_i,
  input  logic [N_DMA-1:0] ack_n_i,
  output logic [N_DMA-1:0] drq_o,
  output logic [N_DMA-1:0] drq_oe_o,
  output logic             ack_n_o
);
  always_comb begin
    drq_o    = '0;
    drq_oe_o = '0;
    ack_n_o  = 1'b1;
    for (int k = 0; k < N_DMA; k++) begin
      if (active_i && en_i && (ch_i == CH_W'(k))) begin
        drq_oe_o[k] = 1'b1;
        drq_o[k]    = req_i;
        ack_n_o     = ack_n_i[k];
      end
    end
  end
endmodule

// File: rtl/req_steer.sv
module req_steer
  import req_steer_pkg::*;
#(
  parameter int N_SRC  = 2,
  parameter int N_BASE = 6,
  parameter int N_DMA  = 2,
  localparam int N_DST = N_BASE + N_DMA,
  localparam int DST_W = $clog2(N_DST),
  localparam int CH_W  = (N_DMA > 1) ? $clog2(N_DMA) : 1,
  localparam int A_W   = $clog2(N_SRC + 2),
  localparam int REG_W = ((DST_W + 1) > (CH_W + 1)) ?
                         (((DST_W + 1) > 2) ? DST_W + 1 : 2) :
                         (((CH_W + 1) > 2) ? CH_W + 1 : 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [A_W-1:0]    cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic [N_SRC-1:0]  irq_in_i,
  input  logic              card_req_pin_i,
  output logic              card_req_pin_o,
  output logic              card_req_pin_oe_o,
  output logic              card_ack_pin_o,
  input  logic [1:0]        cs_n_i,
  output logic [N_BASE-1:0] isa_irq_o,
  output logic [N_BASE-1:0] isa_irq_oe_o,
  output logic [N_DMA-1:0]  isa_dma_pin_o,
  output logic [N_DMA-1:0]  isa_dma_pin_oe_o,
  input  logic [N_DMA-1:0]  isa_ack_pin_i,
  output logic [N_DMA-1:0]  addr_hi_o
);
  mode_t                       mode_q;
  logic [N_SRC-1:0]            route_en;
  logic [N_SRC-1:0][DST_W-1:0] route_dst;
  logic                        dma_en;
  logic [CH_W-1:0]             dma_ch;
  logic                        mode_dma, mode_ext;
  logic [N_DST-1:0]            dst_mask, lvl, lvl_oe;
  logic [N_DMA-1:0]            drq, drq_oe;
  logic                        dack_n;

  req_steer_cfg #(
    .N_SRC(N_SRC), .DST_W(DST_W), .CH_W(CH_W), .A_W(A_W), .REG_W(REG_W)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .mode_o      (mode_q),
    .route_en_o  (route_en),
    .route_dst_o (route_dst),
    .dma_en_o    (dma_en),
    .dma_ch_o    (dma_ch)
  );

  assign mode_dma = (mode_q == MODE_DMA);
  assign mode_ext = (mode_q == MODE_EXT);
  // extra destinations exist only while the shared pins are interrupt lines
  assign dst_mask = {{N_DMA{mode_ext}}, {N_BASE{1'b1}}};

  req_steer_xbar #(
    .N_SRC(N_SRC), .N_DST(N_DST), .DST_W(DST_W)
  ) u_xbar (
    .irq_i      (irq_in_i),
    .en_i       (route_en),
    .dst_i      (route_dst),
    .dst_mask_i (dst_mask),
    .lvl_o      (lvl),
    .oe_o       (lvl_oe)
  );

  req_steer_dma #(
    .N_DMA(N_DMA), .CH_W(CH_W)
  ) u_dma (
    .active_i (mode_dma),
    .en_i     (dma_en),
    .ch_i     (dma_ch),
    .req_i    (card_req_pin_i),
    .ack_n_i  (isa_ack_pin_i),
    .drq_o    (drq),
    .drq_oe_o (drq_oe),
    .ack_n_o  (dack_n)
  );

  assign isa_irq_o        = lvl[N_BASE-1:0];
  assign isa_irq_oe_o     = lvl_oe[N_BASE-1:0];
  assign isa_dma_pin_o    = mode_ext ? lvl[N_DST-1:N_BASE]    : drq;
  assign isa_dma_pin_oe_o = mode_ext ? lvl_oe[N_DST-1:N_BASE] : drq_oe;

  assign card_req_pin_oe_o = mode_ext;
  assign card_req_pin_o    = mode_ext & cs_n_i[0];
  assign card_ack_pin_o    = mode_ext ? cs_n_i[1] : dack_n;
  assign addr_hi_o         = mode_ext ? isa_ack_pin_i : '0;
endmodule

// File: rtl/req_steer_chk.sv
module req_steer_chk
  import req_steer_pkg::*;
#(
  parameter int N_BASE = 6,
  parameter int N_DMA  = 2,
  parameter int A_W    = 2,
  parameter int REG_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [A_W-1:0]    cfg_addr_i,
  input logic [REG_W-1:0]  cfg_wdata_i,
  input mode_t             mode_q,
  input logic [N_BASE-1:0] isa_irq_o,
  input logic [N_BASE-1:0] isa_irq_oe_o,
  input logic [N_DMA-1:0]  isa_dma_pin_o,
  input logic [N_DMA-1:0]  isa_dma_pin_oe_o,
  input logic              card_req_pin_oe_o,
  input logic              card_ack_pin_o,
  input logic [N_DMA-1:0]  addr_hi_o
);
  p_undriven_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((isa_irq_o & ~isa_irq_oe_o) == '0) && ((isa_dma_pin_o & ~isa_dma_pin_oe_o) == '0));

  p_one_channel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DMA) |-> $onehot0(isa_dma_pin_oe_o));

  p_ack_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DMA && isa_dma_pin_oe_o == '0) |-> card_ack_pin_o);

  p_req_pin_role_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_pin_oe_o |-> (mode_q == MODE_EXT));

  p_addr_hi_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_EXT) |-> (addr_hi_o == '0));

  p_reserved_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[1] |-> (card_ack_pin_o && isa_dma_pin_oe_o == '0 && !card_req_pin_oe_o));

  p_mode_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == '0) |=> (mode_q == $past(cfg_wdata_i[1:0])));
endmodule

bind req_steer req_steer_chk #(
  .N_BASE(N_BASE), .N_DMA(N_DMA), .A_W(A_W), .REG_W(REG_W)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cfg_we_i          (cfg_we_i),
  .cfg_addr_i        (cfg_addr_i),
  .cfg_wdata_i       (cfg_wdata_i),
  .mode_q            (mode_q),
  .isa_irq_o         (isa_irq_o),
  .isa_irq_oe_o      (isa_irq_oe_o),
  .isa_dma_pin_o     (isa_dma_pin_o),
  .isa_dma_pin_oe_o  (isa_dma_pin_oe_o),
  .card_req_pin_oe_o (card_req_pin_oe_o),
  .card_ack_pin_o    (card_ack_pin_o),
  .addr_hi_o         (addr_hi_o)
);

// File: tb/req_steer_tb_top.sv
module req_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic [1:0] irq_in = '0;
  logic       req_in = 1'b0;
  logic [1:0] cs_n = 2'b11;
  logic [1:0] ack_in = 2'b11;
  logic       req_o, req_oe, ack_o;
  logic [5:0] irq_o, irq_oe;
  logic [1:0] dma_o, dma_oe, addr_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench copy of the register contents, kept from the writes it makes
  logic [1:0] sh_mode = 2'b00;
  logic [1:0] sh_en = '0;
  logic [2:0] sh_dst [2] = '{3'd0, 3'd0};
  logic       sh_den = 1'b0;
  logic       sh_ch = 1'b0;

  typedef struct {
    string       tag;
    logic [20:0] exp;
  } item_t;
  item_t sb_q[$];
  event  sample_ev;

  always #5 clk = ~clk;

  req_steer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .irq_in_i(irq_in), .card_req_pin_i(req_in),
    .card_req_pin_o(req_o), .card_req_pin_oe_o(req_oe), .card_ack_pin_o(ack_o),
    .cs_n_i(cs_n), .isa_irq_o(irq_o), .isa_irq_oe_o(irq_oe),
    .isa_dma_pin_o(dma_o), .isa_dma_pin_oe_o(dma_oe),
    .isa_ack_pin_i(ack_in), .addr_hi_o(addr_hi)
  );

  function automatic logic [20:0] model();
    logic [7:0] lv, oe;
    logic [1:0] d, doe, ah;
    logic rq, rqoe, ak;
    lv = '0; oe = '0; d = '0; doe = '0; ah = '0;
    rq = 1'b0; rqoe = 1'b0; ak = 1'b1;
    for (int s = 0; s < 2; s++) begin
      if (sh_en[s] && (sh_dst[s] < 3'd6 || sh_mode == 2'b01)) begin
        oe[sh_dst[s]] = 1'b1;
        lv[sh_dst[s]] = lv[sh_dst[s]] | irq_in[s];
      end
    end
    if (sh_mode == 2'b01) begin
      d = lv[7:6]; doe = oe[7:6];
      rq = cs_n[0]; rqoe = 1'b1; ak = cs_n[1]; ah = ack_in;
    end else if (sh_mode == 2'b00 && sh_den) begin
      doe[sh_ch] = 1'b1; d[sh_ch] = req_in; ak = ack_in[sh_ch];
    end
    return {lv[5:0], oe[5:0], d, doe, rq, rqoe, ak, ah};
  endfunction

  task automatic check(input string tag);
    item_t it;
    it.tag = tag;
    it.exp = model();
    sb_q.push_back(it);
    -> sample_ev;
    #2;
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      #1;
      begin
        item_t it;
        logic [20:0] act;
        it = sb_q.pop_front();
        act = {irq_o, irq_oe, dma_o, dma_oe, req_o, req_oe, ack_o, addr_hi};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    case (a)
      2'd0: sh_mode = v[1:0];
      2'd1: begin sh_en[0] = v[3]; sh_dst[0] = v[2:0]; end
      2'd2: begin sh_en[1] = v[3]; sh_dst[1] = v[2:0]; end
      default: begin sh_den = v[1]; sh_ch = v[0]; end
    endcase
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    irq_in = 2'b11; ack_in = 2'b00; req_in = 1'b1;
    repeat (3) @(posedge clk);
    #3 check("R1 reset state");
    rst_n = 1'b1;
    @(posedge clk); #3;
    check("R1 after reset release");

    wr(2'd1, 4'b1010);                       // src0 -> line 2
    irq_in = 2'b01; check("R2 src0 high on line2");
    irq_in = 2'b00; check("R2 src0 low on line2");
    irq_in = 2'b10; check("R4 src1 unrouted");

    wr(2'd2, 4'b1010);                       // src1 -> line 2 too
    irq_in = 2'b10; check("R3 OR src1 only");
    irq_in = 2'b01; check("R3 OR src0 only");
    irq_in = 2'b00; check("R3 OR none");

    wr(2'd2, 4'b1101);                       // src1 -> line 5
    irq_in = 2'b11; check("R2 two lines driven");
    wr(2'd2, 4'b1111);                       // src1 -> line 7 in DMA mode
    check("R5 dest7 dropped in mode 00");

    wr(2'd0, 4'b0001);                       // extended mode
    irq_in = 2'b10; cs_n = 2'b10; ack_in = 2'b01;
    check("R5 dest7 on shared pin1");
    irq_in = 2'b00; cs_n = 2'b01; ack_in = 2'b10;
    check("R8 chip selects and address bits");

    wr(2'd2, 4'b0000);
    wr(2'd0, 4'b0000);                       // back to DMA mode
    check("R6 dma disabled");
    wr(2'd3, 4'b0010);                       // enable, channel 0
    req_in = 1'b1; ack_in = 2'b10; check("R6 R7 channel0 active");
    req_in = 1'b0; ack_in = 2'b01; check("R7 channel0 ack idle");
    wr(2'd3, 4'b0011);                       // channel 1
    req_in = 1'b1; ack_in = 2'b01; check("R6 R7 channel1 active");
    ack_in = 2'b10; check("R7 channel1 ack idle");
    wr(2'd3, 4'b0001);                       // disabled
    ack_in = 2'b00; check("R7 ack high while disabled");

    wr(2'd3, 4'b0010);
    wr(2'd0, 4'b0010);                       // reserved code
    irq_in = 2'b01; ack_in = 2'b00; check("R9 mode 10");
    wr(2'd0, 4'b0011);
    check("R9 mode 11");

    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 4'b1101;
    #2 check("R10 write not yet taken");
    @(posedge clk); #1;
    cfg_we = 1'b0; sh_mode = 2'b01;
    check("R10 mode taken at edge");

    #5;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule